// File: doc/BRIEF.md
# Virtual Interrupt Flag Controller

This block holds the interrupt-enable state of a core that runs 16-bit code under a supervisor. On each cycle it receives one instruction class (clear-interrupt, set-interrupt, push-flags, pop-flags or none) along with the virtual-extension enable and the two-bit I/O privilege level. From these it updates three flags: the real interrupt enable (IF), the virtual interrupt enable (VIF) and the virtual interrupt pending flag (VIP).

The block works in one of three modes. At full I/O privilege the instructions act directly on IF. Below full privilege with the extension on, they are redirected to VIF. Below full privilege with the extension off, every one of them is refused with a general-protection fault request. In the redirected mode, any attempt to turn VIF on while VIP is already set becomes a fault instead. The controller only tests VIP. Supervisor software changes it through a dedicated write port.

For push-flags, the block produces a 16-bit image: the core's other flag bits, with the interrupt-enable position filled in from the flag that applies in the current mode. All results are registered and appear one clock after the instruction is presented.

Top module: `vif_flag_ctrl`

## Requirements
- R1: After a synchronous reset, if_flag, vif_flag, vip_flag, gp_fault, push_valid and push_img are all 0.
- R2: Instruction codes on op_code are 0 none, 1 clear-interrupt, 2 set-interrupt, 3 push-flags and 4 pop-flags. Codes 5 to 7 change no flag and raise neither gp_fault nor push_valid.
- R3: When iopl is 3, whatever vme_en is: clear-interrupt clears IF, set-interrupt sets IF, and pop-flags loads IF from bit 9 of pop_word. VIF is untouched and VIP is never tested.
- R4: When vme_en is 1 and iopl is below 3, clear-interrupt clears VIF and leaves IF unchanged.
- R5: In the same mode, set-interrupt with VIP at 0 sets VIF and leaves IF unchanged.
- R6: In the same mode, set-interrupt with VIP at 1 raises gp_fault and leaves VIF and IF unchanged.
- R7: In the same mode, pop-flags copies bit 9 of pop_word into VIF and leaves IF unchanged. A popped 0 never faults, even when VIP is 1.
- R8: In the same mode, pop-flags with bit 9 of pop_word at 1 while VIP is 1 raises gp_fault and leaves VIF unchanged.
- R9: Push-flags asserts push_valid for one cycle. push_img equals base_flags with bit 9 replaced by IF when iopl is 3, or by VIF when vme_en is 1 and iopl is below 3.
- R10: When vme_en is 0 and iopl is below 3, all four flag instructions raise gp_fault, change no flag and do not assert push_valid.
- R11: VIP changes only when vip_wr_en is 1, and then takes vip_wr_val one cycle later. The VIP test for an instruction uses the VIP value held before that same cycle's write.
- R12: Outputs follow the instruction by one clock. gp_fault is high for exactly the one cycle after each faulting instruction, and the flags in that cycle are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 3 | Instruction class for this cycle |
| vme_en | input | 1 | Virtual interrupt extension enable |
| iopl | input | 2 | Current I/O privilege level |
| pop_word | input | 16 | Word popped by pop-flags |
| base_flags | input | 16 | Core's other flag bits for the push image |
| vip_wr_en | input | 1 | Supervisor write strobe for VIP |
| vip_wr_val | input | 1 | Value written to VIP |
| if_flag | output | 1 | Real interrupt enable |
| vif_flag | output | 1 | Virtual interrupt enable |
| vip_flag | output | 1 | Virtual interrupt pending |
| push_img | output | 16 | Flag image to push |
| push_valid | output | 1 | push_img is new this cycle |
| gp_fault | output | 1 | General-protection fault request pulse |

## Verification
A write to VIP and a set-interrupt instruction can arrive in the same cycle. The bench provokes this by clearing VIP through the write port while a redirected set-interrupt is presented with VIP still at 1. The instruction must fault, because it tests the old VIP, and VIP must read 0 afterwards, after which a plain set-interrupt succeeds. The other same-cycle case, a pending VIP meeting a pop-flags, is judged on the popped bit: the bench expects a fault for a popped 1 and none for a popped 0.

// File: rtl/vif_pkg.sv
package vif_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_CLI   = 3'd1,
    OP_STI   = 3'd2,
    OP_PUSHF = 3'd3,
    OP_POPF  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    MODE_NATIVE = 2'd0,
    MODE_VIRT   = 2'd1,
    MODE_TRAP   = 2'd2
  } mode_e;
endpackage

// File: rtl/vif_mode_decode.sv
module vif_mode_decode
  import vif_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  logic            vme_en,
  input  logic [PL_W-1:0] iopl,
  output mode_e           mode
);
  localparam logic [PL_W-1:0] PL_MAX = {PL_W{1'b1}};

  always_comb begin
    if (iopl == PL_MAX)  mode = MODE_NATIVE;
    else if (vme_en)     mode = MODE_VIRT;
    else                 mode = MODE_TRAP;
  end
endmodule

// File: rtl/vif_flag_next.sv
module vif_flag_next
  import vif_pkg::*;
(
  input  logic [2:0] op_code,
  input  mode_e      mode,
  input  logic       if_q,
  input  logic       vif_q,
  input  logic       vip_q,
  input  logic       pop_if,
  output logic       if_n,
  output logic       vif_n,
  output logic       fault_n,
  output logic       push_n,
  output logic       img_bit
);
  logic flag_op;
  assign flag_op = (op_code >= 3'(OP_CLI)) && (op_code <= 3'(OP_POPF));

  always_comb begin
    if_n    = if_q;
    vif_n   = vif_q;
    fault_n = 1'b0;
    push_n  = 1'b0;
    img_bit = if_q;
    case (mode)
      MODE_NATIVE: begin
        case (op_code)
          3'(OP_CLI):   if_n = 1'b0;
          3'(OP_STI):   if_n = 1'b1;
          3'(OP_POPF):  if_n = pop_if;
          3'(OP_PUSHF): push_n = 1'b1;
          default: ;
        endcase
      end
      MODE_VIRT: begin
        img_bit = vif_q;
        case (op_code)
          3'(OP_CLI): vif_n = 1'b0;
          3'(OP_STI): begin
            if (vip_q) fault_n = 1'b1;
            else       vif_n = 1'b1;
          end
          3'(OP_POPF): begin
            if (pop_if && vip_q) fault_n = 1'b1;
            else                 vif_n = pop_if;
          end
          3'(OP_PUSHF): push_n = 1'b1;
          default: ;
        endcase
      end
      default: fault_n = flag_op;
    endcase
  end
endmodule

// File: rtl/vif_push_image.sv
module vif_push_image #(
  parameter int W      = 16,
  parameter int IF_POS = 9
) (
  input  logic [W-1:0] base_flags,
  input  logic         img_bit,
  output logic [W-1:0] img
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == IF_POS) begin : g_if
      assign img[i] = img_bit;
    end else begin : g_pass
      assign img[i] = base_flags[i];
    end
  end
endmodule

// File: rtl/vif_flag_ctrl.sv
module vif_flag_ctrl
  import vif_pkg::*;
#(
  parameter int W      = 16,
  parameter int IF_POS = 9,
  parameter int PL_W   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      op_code,
  input  logic            vme_en,
  input  logic [PL_W-1:0] iopl,
  input  logic [W-1:0]    pop_word,
  input  logic [W-1:0]    base_flags,
  input  logic            vip_wr_en,
  input  logic            vip_wr_val,
  output logic            if_flag,
  output logic            vif_flag,
  output logic            vip_flag,
  output logic [W-1:0]    push_img,
  output logic            push_valid,
  output logic            gp_fault
);
  mode_e       mode;
  logic        if_n, vif_n, fault_n, push_n, img_bit;
  logic [W-1:0] img_n;
  logic        pop_unused;

  assign pop_unused = &{1'b0, pop_word};

  vif_mode_decode #(.PL_W(PL_W)) u_mode (
    .vme_en (vme_en),
    .iopl   (iopl),
    .mode   (mode)
  );

  vif_flag_next u_next (
    .op_code (op_code),
    .mode    (mode),
    .if_q    (if_flag),
    .vif_q   (vif_flag),
    .vip_q   (vip_flag),
    .pop_if  (pop_word[IF_POS]),
    .if_n    (if_n),
    .vif_n   (vif_n),
    .fault_n (fault_n),
    .push_n  (push_n),
    .img_bit (img_bit)
  );

  vif_push_image #(.W(W), .IF_POS(IF_POS)) u_img (
    .base_flags (base_flags),
    .img_bit    (img_bit),
    .img        (img_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      if_flag    <= 1'b0;
      vif_flag   <= 1'b0;
      vip_flag   <= 1'b0;
      push_img   <= '0;
      push_valid <= 1'b0;
      gp_fault   <= 1'b0;
    end else begin
      if_flag    <= if_n;
      vif_flag   <= vif_n;
      gp_fault   <= fault_n;
      push_valid <= push_n;
      if (push_n)    push_img <= img_n;
      if (vip_wr_en) vip_flag <= vip_wr_val;
    end
  end

  // R12: a fault leaves the flags as they were
  a_r12_fault_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    gp_fault |-> ($stable(if_flag) && $stable(vif_flag)));

  // R11: VIP moves only through the write port
  a_r11_vip_write_only: assert property (@(posedge clk) disable iff (rst)
    !vip_wr_en |=> $stable(vip_flag));

  // R4 / R5 / R7: redirected instructions never touch IF
  a_r4_virt_if_stable: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_VIRT) |=> $stable(if_flag));

  // R6 / R8: VIF cannot turn on while VIP was pending
  a_r6_vif_rise_needs_no_vip: assert property (@(posedge clk) disable iff (rst)
    $rose(vif_flag) |-> !$past(vip_flag));

  // R10: refused instructions fault and push nothing
  a_r10_trap_faults: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_TRAP) && (op_code >= 3'(OP_CLI)) && (op_code <= 3'(OP_POPF)))
    |=> (gp_fault && !push_valid));

  // R9: a push and a fault never share a cycle
  a_r9_push_excl_fault: assert property (@(posedge clk) disable iff (rst)
    gp_fault |-> !push_valid);
endmodule

// File: tb/tb_vif_flag_ctrl.sv
module tb_vif_flag_ctrl;
  localparam int W = 16;
  localparam int NV = 28;
  localparam logic [W-1:0] BASE = 16'hA0D5;

  logic clk = 1'b0;
  logic rst;
  logic [2:0] op_code;
  logic vme_en;
  logic [1:0] iopl;
  logic [W-1:0] pop_word;
  logic [W-1:0] base_flags;
  logic vip_wr_en, vip_wr_val;
  logic if_flag, vif_flag, vip_flag, push_valid, gp_fault;
  logic [W-1:0] push_img;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vif_flag_ctrl dut (
    .clk(clk), .rst(rst), .op_code(op_code), .vme_en(vme_en), .iopl(iopl),
    .pop_word(pop_word), .base_flags(base_flags), .vip_wr_en(vip_wr_en),
    .vip_wr_val(vip_wr_val), .if_flag(if_flag), .vif_flag(vif_flag),
    .vip_flag(vip_flag), .push_img(push_img), .push_valid(push_valid),
    .gp_fault(gp_fault)
  );

  // {op, vme, iopl, pop_if, wr_en, wr_val, exp_if, exp_vif, exp_vip, exp_fault, exp_push, exp_img_if}
  localparam logic [14:0] VEC [0:NV-1] = '{
    {3'd2, 1'b0, 2'd3, 3'b000, 6'b100000}, // R3 native set
    {3'd3, 1'b1, 2'd3, 3'b000, 6'b100011}, // R9 native push IF=1
    {3'd1, 1'b0, 2'd3, 3'b000, 6'b000000}, // R3 native clear
    {3'd4, 1'b0, 2'd3, 3'b100, 6'b100000}, // R3 native pop 1
    {3'd2, 1'b1, 2'd0, 3'b000, 6'b110000}, // R5 virtual set
    {3'd1, 1'b1, 2'd0, 3'b000, 6'b100000}, // R4 virtual clear
    {3'd3, 1'b1, 2'd0, 3'b000, 6'b100010}, // R9 virtual push VIF=0
    {3'd0, 1'b1, 2'd0, 3'b011, 6'b101000}, // R11 write VIP=1
    {3'd2, 1'b1, 2'd1, 3'b000, 6'b101100}, // R6 set with VIP
    {3'd4, 1'b1, 2'd0, 3'b100, 6'b101100}, // R8 pop 1 with VIP
    {3'd4, 1'b1, 2'd0, 3'b000, 6'b101000}, // R7 pop 0 with VIP, no fault
    {3'd2, 1'b1, 2'd0, 3'b010, 6'b100100}, // R11 same-cycle clear, old VIP used
    {3'd2, 1'b1, 2'd0, 3'b000, 6'b110000}, // R5
    {3'd4, 1'b1, 2'd0, 3'b000, 6'b100000}, // R7 pop 0
    {3'd4, 1'b1, 2'd0, 3'b100, 6'b110000}, // R7 pop 1
    {3'd3, 1'b1, 2'd2, 3'b000, 6'b110011}, // R9 virtual push VIF=1
    {3'd1, 1'b0, 2'd1, 3'b000, 6'b110100}, // R10 clear refused
    {3'd3, 1'b0, 2'd1, 3'b000, 6'b110100}, // R10 push refused
    {3'd4, 1'b0, 2'd0, 3'b000, 6'b110100}, // R10 pop refused
    {3'd2, 1'b0, 2'd2, 3'b000, 6'b110100}, // R10 set refused
    {3'd1, 1'b0, 2'd3, 3'b000, 6'b010000}, // R3 native clear, VIF kept
    {3'd3, 1'b1, 2'd3, 3'b000, 6'b010010}, // R9 native push uses IF
    {3'd7, 1'b1, 2'd0, 3'b100, 6'b010000}, // R2 unused code
    {3'd1, 1'b1, 2'd0, 3'b000, 6'b000000}, // R4
    {3'd0, 1'b1, 2'd0, 3'b011, 6'b001000}, // R11 VIP=1
    {3'd2, 1'b1, 2'd2, 3'b000, 6'b001100}, // R6
    {3'd0, 1'b1, 2'd0, 3'b000, 6'b001000}, // R11 idle, pulse over
    {3'd4, 1'b0, 2'd3, 3'b100, 6'b101000}  // R3 native pop ignores VIP
  };

  function automatic string req_of(input logic [2:0] op, input logic vme,
                                   input logic [1:0] pl, input logic wen);
    if (op > 3'd4)       return "R2";
    if (op == 3'd0 || wen) return "R11";
    if (pl == 2'd3)      return (op == 3'd3) ? "R9" : "R3";
    if (!vme)            return "R10";
    case (op)
      3'd1:    return "R4";
      3'd2:    return "R5/R6";
      3'd3:    return "R9";
      default: return "R7/R8";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic vme, input logic [1:0] pl,
                       input logic pop_if, input logic wen, input logic wval);
    op_code    = op;
    vme_en     = vme;
    iopl       = pl;
    pop_word   = 16'h5C3A;
    pop_word[9] = pop_if;
    vip_wr_en  = wen;
    vip_wr_val = wval;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    base_flags = BASE;
    drive(3'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    // R1: reset state
    chk("R1", "if",    W'(if_flag),    '0);
    chk("R1", "vif",   W'(vif_flag),   '0);
    chk("R1", "vip",   W'(vip_flag),   '0);
    chk("R1", "fault", W'(gp_fault),   '0);
    chk("R1", "push",  W'(push_valid), '0);
    chk("R1", "img",   push_img,       '0);

    for (int i = 0; i < NV; i++) begin
      logic [14:0] v;
      string r;
      logic [W-1:0] eimg;
      v = VEC[i];
      drive(v[14:12], v[11], v[10:9], v[8], v[7], v[6]);
      r = req_of(v[14:12], v[11], v[10:9], v[7]);
      @(posedge clk);
      #1;
      chk(r, "if",    W'(if_flag),    W'(v[5]));
      chk(r, "vif",   W'(vif_flag),   W'(v[4]));
      chk(r, "vip",   W'(vip_flag),   W'(v[3]));
      chk(r, "fault", W'(gp_fault),   W'(v[2]));
      chk(r, "push",  W'(push_valid), W'(v[1]));
      if (v[1]) begin
        eimg = BASE;
        eimg[9] = v[0];
        chk("R9", "img", push_img, eimg);
      end
    end

    // R12: fault pulse lasts one cycle; state now IF=1 VIF=0 VIP=1
    drive(3'd2, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
    @(posedge clk);
    #1;
    chk("R12", "fault pulse", W'(gp_fault), W'(1'b1));
    chk("R12", "vif held",    W'(vif_flag), W'(1'b0));
    drive(3'd0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
    @(posedge clk);
    #1;
    chk("R12", "fault end",   W'(gp_fault), W'(1'b0));

    // R1: mid-run reset clears set flags
    drive(3'd2, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1);
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    drive(3'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R1", "if after reset",  W'(if_flag),  '0);
    chk("R1", "vip after reset", W'(vip_flag), '0);
    chk("R1", "vif after reset", W'(vif_flag), '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule